// File: doc/BRIEF.md
# Concatenation-Incrementation Carry-Skip Stage

This block is one slice of a carry-skip adder, built so that every slice of a wide adder can start work as soon as its operands arrive. Inside the slice, a ripple-carry chain adds the two operand slices with its carry-in held at zero. The slice therefore never waits for its neighbour to produce an intermediate sum and a local carry. When the carry from the previous slice arrives, a chain of half adders adds it into the intermediate sum. A single inverting compound gate forms the outgoing carry from three signals: the local carry, the group propagate and the incoming carry. This gate takes the place of the usual 2:1 skip multiplexer.

A parameter selects one of three kinds of slice. The head slice sits at the least significant end: it feeds the true external carry into its ripple chain and has no increment chain. An AND-OR-Invert slice takes a true carry and drives out an inverted one. An OR-AND-Invert slice takes an inverted carry and drives out a true one. In a chain the last two kinds alternate, so no inverter is needed between slices. The sum and the carry are registered, which gives one clock of latency.

Top module: `ci_skip_stage`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, that edge clears `sum_o` to all zeros and clears `carry_o` to 0, whatever the inputs are.
- R2: The outputs change only at a rising clock edge. A value applied at the inputs shows up at the outputs after the next rising edge, and the outputs do not move before that edge.
- R3: With KIND = STAGE_HEAD, `carry_i` is the true carry and `carry_o` is the true carry. `{carry_o, sum_o}` equals `a_i + b_i + carry_i`, computed WIDTH+1 bits wide.
- R4: With KIND = STAGE_AOI, `carry_i` is active high and `carry_o` is active low. `{~carry_o, sum_o}` equals `a_i + b_i + carry_i`.
- R5: With KIND = STAGE_OAI, `carry_i` is active low and `carry_o` is active high. `{carry_o, sum_o}` equals `a_i + b_i + ~carry_i`.
- R6: When every bit of `a_i ^ b_i` is 1 (the slice fully propagates), the true outgoing carry equals the true incoming carry.
- R7: When `a_i + b_i` generates a carry by itself, the true outgoing carry is 1 whatever the incoming carry is. In every case, the carry formed by the skip gate equals the local ripple carry OR the carry out of the increment chain.
- R8: When the true incoming carry is 0, `sum_o` equals the low WIDTH bits of `a_i + b_i`.
- R9: The slice works correctly at a width of one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | First operand slice |
| b_i | input | WIDTH | Second operand slice |
| carry_i | input | 1 | Incoming carry; active low when KIND is STAGE_OAI |
| sum_o | output | WIDTH | Registered sum slice |
| carry_o | output | 1 | Registered outgoing carry; active low when KIND is STAGE_AOI |

## Verification
The hardest case to reach from the ports is the one where the skip path alone decides the carry. That happens only when every bit of the slice propagates, so the local ripple carry is zero and the incoming carry has to pass through the compound gate. A random stimulus at WIDTH = 4 hits this case once in sixteen vectors. Sweeping every operand pair with both carry values reaches every propagate pattern and every generate pattern. The sweep drives the head, inverting-AND and inverting-OR kinds in the same run, and also drives a one-bit slice.

// File: rtl/ci_skip_pkg.sv
`timescale 1ns/1ps
package ci_skip_pkg;
  typedef enum logic [1:0] {
    STAGE_HEAD = 2'd0,
    STAGE_AOI  = 2'd1,
    STAGE_OAI  = 2'd2
  } stage_kind_e;

  // The incoming carry is active low only on the OR-AND-Invert kind.
  function automatic logic carry_in_low(stage_kind_e kind);
    return (kind == STAGE_OAI);
  endfunction

  // The outgoing carry is active low only on the AND-OR-Invert kind.
  function automatic logic carry_out_low(stage_kind_e kind);
    return (kind == STAGE_AOI);
  endfunction
endpackage

// File: rtl/ci_ripple.sv
`timescale 1ns/1ps
module ci_ripple #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             grp_prop_o
);
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] prop;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign prop[i]    = a_i[i] ^ b_i[i];
    assign sum_o[i]   = prop[i] ^ chain[i];
    assign chain[i+1] = (a_i[i] & b_i[i]) | (prop[i] & chain[i]);
  end

  assign cout_o     = chain[WIDTH];
  assign grp_prop_o = &prop;
endmodule

// File: rtl/ci_incr.sv
`timescale 1ns/1ps
module ci_incr #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] part_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] hc;

  assign hc[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_ha
    assign sum_o[i] = part_i[i] ^ hc[i];
    assign hc[i+1]  = part_i[i] & hc[i];
  end

  assign cout_o = hc[WIDTH];
endmodule

// File: rtl/ci_skip_gate.sv
`timescale 1ns/1ps
module ci_skip_gate
  import ci_skip_pkg::*;
#(
  parameter stage_kind_e KIND = STAGE_AOI
) (
  input  logic grp_prop_i,
  input  logic loc_carry_i,
  input  logic cin_raw_i,
  output logic cout_raw_o
);
  if (KIND == STAGE_AOI) begin : g_aoi
    // true carry in, inverted carry out
    assign cout_raw_o = ~((grp_prop_i & cin_raw_i) | loc_carry_i);
  end else if (KIND == STAGE_OAI) begin : g_oai
    // inverted carry in, true carry out
    assign cout_raw_o = ~((~grp_prop_i | cin_raw_i) & ~loc_carry_i);
  end else begin : g_head
    // the ripple chain already saw the true carry; the skip term adds nothing wrong
    assign cout_raw_o = loc_carry_i | (grp_prop_i & cin_raw_i);
  end
endmodule

// File: rtl/ci_skip_stage.sv
`timescale 1ns/1ps
module ci_skip_stage
  import ci_skip_pkg::*;
#(
  parameter int          WIDTH = 8,
  parameter stage_kind_e KIND  = STAGE_AOI
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam logic CIN_LOW  = carry_in_low(KIND);
  localparam logic IS_HEAD  = (KIND == STAGE_HEAD);

  logic             cin_true;
  logic             ripple_cin;
  logic [WIDTH-1:0] loc_sum;
  logic             loc_carry;
  logic             grp_prop;
  logic [WIDTH-1:0] final_sum;
  logic             inc_carry;
  logic             carry_raw;

  assign cin_true   = carry_i ^ CIN_LOW;
  assign ripple_cin = IS_HEAD ? cin_true : 1'b0;

  ci_ripple #(.WIDTH(WIDTH)) u_ripple (
    .a_i        (a_i),
    .b_i        (b_i),
    .cin_i      (ripple_cin),
    .sum_o      (loc_sum),
    .cout_o     (loc_carry),
    .grp_prop_o (grp_prop)
  );

  if (IS_HEAD) begin : g_no_incr
    assign final_sum = loc_sum;
    assign inc_carry = 1'b0;
  end else begin : g_incr
    ci_incr #(.WIDTH(WIDTH)) u_incr (
      .part_i (loc_sum),
      .cin_i  (cin_true),
      .sum_o  (final_sum),
      .cout_o (inc_carry)
    );
  end

  ci_skip_gate #(.KIND(KIND)) u_skip (
    .grp_prop_i  (grp_prop),
    .loc_carry_i (loc_carry),
    .cin_raw_i   (carry_i),
    .cout_raw_o  (carry_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      sum_o   <= final_sum;
      carry_o <= carry_raw;
    end
  end
endmodule

// File: rtl/ci_skip_stage_chk.sv
`timescale 1ns/1ps
module ci_skip_stage_chk
  import ci_skip_pkg::*;
#(
  parameter int          WIDTH = 8,
  parameter stage_kind_e KIND  = STAGE_AOI
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             loc_carry,
  input logic             inc_carry,
  input logic             skip_raw
);
  logic           ci_t;
  logic           co_t;
  logic           sk_t;
  logic [WIDTH:0] exp_total;
  logic [WIDTH:0] exp_plain;

  assign ci_t      = carry_i ^ carry_in_low(KIND);
  assign co_t      = carry_o ^ carry_out_low(KIND);
  assign sk_t      = skip_raw ^ carry_out_low(KIND);
  assign exp_plain = {1'b0, a_i} + {1'b0, b_i};
  assign exp_total = exp_plain + {{WIDTH{1'b0}}, ci_t};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (sum_o == '0 && carry_o == 1'b0));

  // R3 R4 R5 R2
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({co_t, sum_o} == $past(exp_total)));

  // R6
  skip_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(&(a_i ^ b_i))) |-> (co_t == $past(ci_t)));

  // R7
  skip_merge_chk: assert property (@(posedge clk) disable iff (rst)
    sk_t == (loc_carry | inc_carry));

  // R8
  zero_cin_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ci_t)) |-> (sum_o == $past(exp_plain[WIDTH-1:0])));
endmodule

bind ci_skip_stage ci_skip_stage_chk #(.WIDTH(WIDTH), .KIND(KIND)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .a_i       (a_i),
  .b_i       (b_i),
  .carry_i   (carry_i),
  .sum_o     (sum_o),
  .carry_o   (carry_o),
  .loc_carry (loc_carry),
  .inc_carry (inc_carry),
  .skip_raw  (carry_raw)
);

// File: tb/ci_skip_stage_bench.sv
`timescale 1ns/1ps
module ci_skip_stage_bench;
  import ci_skip_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = 4'd0;
  logic [3:0] b = 4'd0;
  logic       c = 1'b0;
  logic       c_n;
  logic [3:0] s_aoi, s_head, s_oai;
  logic       k_aoi, k_head, k_oai;
  logic [0:0] s_nar;
  logic       k_nar;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  assign c_n = ~c;

  always #10 clk = ~clk;

  ci_skip_stage #(.WIDTH(4), .KIND(STAGE_AOI)) u_ci_skip_stage (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .carry_i(c), .sum_o(s_aoi), .carry_o(k_aoi));
  ci_skip_stage #(.WIDTH(4), .KIND(STAGE_HEAD)) u_head (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .carry_i(c), .sum_o(s_head), .carry_o(k_head));
  ci_skip_stage #(.WIDTH(4), .KIND(STAGE_OAI)) u_oai (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .carry_i(c_n), .sum_o(s_oai), .carry_o(k_oai));
  ci_skip_stage #(.WIDTH(1), .KIND(STAGE_AOI)) u_narrow (
    .clk(clk), .rst(rst), .a_i(a[0]), .b_i(b[0]), .carry_i(c), .sum_o(s_nar), .carry_o(k_nar));

  task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d c=%0d got=%h exp=%h", tag, a, b, c, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] tot;
    // R1: reset with busy inputs
    a = 4'hF; b = 4'hF; c = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 head",   {k_head, s_head}, 5'd0);
    chk("R1 aoi",    {k_aoi,  s_aoi},  5'd0);
    chk("R1 oai",    {k_oai,  s_oai},  5'd0);
    chk("R1 narrow", {3'd0, k_nar, s_nar}, 5'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 head after reset", {k_head, s_head}, 5'd31);
    // R2: new inputs do not reach outputs before the edge
    a = 4'd3; b = 4'd4; c = 1'b0;
    #5;
    chk("R2 hold before edge", {k_head, s_head}, 5'd31);
    @(negedge clk);
    chk("R2 update after edge", {k_head, s_head}, 5'd7);

    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        for (int ic = 0; ic < 2; ic++) begin
          a = 4'(ia); b = 4'(ib); c = 1'(ic);
          @(negedge clk);
          tot = 5'(ia + ib + ic);
          chk("R3 head", {k_head, s_head}, tot);
          chk("R4 aoi",  {~k_aoi, s_aoi},  tot);
          chk("R5 oai",  {k_oai,  s_oai},  tot);
          chk("R9 narrow", {3'd0, ~k_nar, s_nar}, 5'((ia & 1) + (ib & 1) + ic));
          if ((a ^ b) == 4'hF) begin
            chk("R6 aoi skip", {4'd0, ~k_aoi}, {4'd0, c});
            chk("R6 oai skip", {4'd0, k_oai},  {4'd0, c});
          end
          if (ia + ib > 15) begin
            chk("R7 aoi generate", {4'd0, ~k_aoi}, 5'd1);
            chk("R7 oai generate", {4'd0, k_oai},  5'd1);
          end
          if (ic == 0) begin
            chk("R8 aoi zero carry", {1'b0, s_aoi}, {1'b0, 4'(ia + ib)});
            chk("R8 oai zero carry", {1'b0, s_oai}, {1'b0, 4'(ia + ib)});
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule